// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Status Queue

This block turns an asynchronous serial line into characters. A baud tick at sixteen times the bit rate drives it. A falling edge on the line is taken as a possible start bit. The start bit is confirmed half a bit later, and each data bit, the optional parity slot and the stop bit are then sampled at their centres. The character length is set by a two-bit code. The parity mode is set by a second two-bit code, which also selects a multidrop mode. In multidrop mode the parity slot carries an address/data marker.

Every received character goes into a small queue together with its own three status flags: break, framing and parity. The head of the queue is always on the outputs, and a one-cycle read strobe consumes it. If a character completes while the queue is full, it waits in a single holding stage. If another character then begins, the waiting character is lost and a sticky overrun flag is raised. Only a pulse on the error-clear input removes that flag.

A line held low for a whole character, stop slot included, is reported once as a break. After that the receiver ignores the line until it has been high for half a bit.

Top module: `uart_rx_status`

## Requirements
- R1: Sixteen baud ticks make one bit time. A start bit is accepted only if the line is still low on the eighth tick after the falling edge. Data bits are then sampled every sixteen ticks, least significant bit first. The number of data bits is 5 + `len_code` (00 = 5, 11 = 8), and unused upper bits of `rx_data` read 0.
- R2: `par_mode` 00 means no parity slot, 01 even, 10 odd and 11 multidrop. In even or odd mode, `rx_perr` of an entry is 1 exactly when the received parity bit does not match the data. In mode 00 it is 0.
- R3: In multidrop mode `rx_perr` of an entry holds the value received in the parity slot.
- R4: The stop bit is sampled at its centre. A low sample gives the entry `rx_ferr` = 1.
- R5: A character whose data bits, parity slot (if present) and stop bit are all low is stored as one entry with `rx_break` = 1, `rx_ferr` = 1, `rx_perr` = 0 and data 0.
- R6: After a break no new character is accepted until the line has been high for eight consecutive baud ticks. Shorter high pulses do not end the wait.
- R7: Entries leave in arrival order. `rx_ready` is high while at least one entry is held. A `rd_strobe` pulse removes the head, and the next head is on the outputs from the following cycle. The head does not change unless it is read.
- R8: `fifo_full` is high while three entries are held. A fourth completed character waits in a holding stage and enters the queue when the head is read.
- R9: If a start bit is accepted while the queue is full and the holding stage is occupied, the held character and its flags are discarded and `overrun` rises. `overrun` never rises unless the queue is full.
- R10: `overrun` stays set until a `clr_err` pulse, and `clr_err` leaves the stored entries untouched.
- R11: After reset `rx_ready`, `fifo_full` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| len_code | input | 2 | Data bits minus five |
| par_mode | input | 2 | 00 none, 01 even, 10 odd, 11 multidrop |
| rd_strobe | input | 1 | Consume the head entry |
| clr_err | input | 1 | Clear the overrun flag |
| rx_ready | output | 1 | At least one entry held |
| fifo_full | output | 1 | Queue holds three entries |
| overrun | output | 1 | Sticky lost-character flag |
| rx_data | output | 8 | Head entry data |
| rx_break | output | 1 | Head entry break flag |
| rx_ferr | output | 1 | Head entry framing flag |
| rx_perr | output | 1 | Head entry parity or address/data flag |

## Verification
The bench feeds five-bit and eight-bit characters, good and corrupted parity, and both values of the multidrop marker. A design that masks the length wrongly, or inverts the sense of parity, returns wrong data or a wrong flag at the head.

A long break is followed by a short high glitch and then more low time. A design that ends the break wait too early would store extra break entries.

Five characters are sent without any read, so the fourth must be dropped rather than the fifth. The reads show whether the holding stage drains in order, whether the overrun flag survives reads, and whether `clr_err` clears the flag without disturbing the queue.

// File: rtl/urx_pkg.sv
package urx_pkg;

    localparam int DATA_W = 8;
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_START,
        RS_DATA,
        RS_PAR,
        RS_STOP,
        RS_BRKWAIT
    } rx_state_t;

    typedef enum logic [1:0] {
        PM_NONE = 2'b00,
        PM_EVEN = 2'b01,
        PM_ODD  = 2'b10,
        PM_ADDR = 2'b11
    } par_mode_t;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // number of data bits selected by the two-bit length code
    function automatic logic [3:0] char_bits(input logic [1:0] code);
        return 4'(MIN_BITS) + {2'b00, code};
    endfunction

    // parity flag: mismatch in even/odd, raw slot value in multidrop
    function automatic logic par_flag(input logic [DATA_W-1:0] d,
                                      input logic pbit,
                                      input par_mode_t mode);
        logic f;
        unique case (mode)
            PM_NONE: f = 1'b0;
            PM_EVEN: f = (^d) ^ pbit;
            PM_ODD:  f = ~((^d) ^ pbit);
            PM_ADDR: f = pbit;
            default: f = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/urx_sampler.sv
module urx_sampler
    import urx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd_async,
    input  logic [1:0] len_code,
    input  par_mode_t mode,
    output logic      start_ok,
    output logic      char_done,
    output rx_entry_t char_out
);

    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
    localparam int BW = $clog2(DATA_W);

    logic [1:0]        sync_q;
    logic              rx;
    rx_state_t         state;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bit_idx;
    logic [BW-1:0]     last_bit;
    logic [DATA_W-1:0] shreg;
    logic              pbit;
    logic              frame_brk;
    rx_entry_t         frame_entry;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd_async};
    end
    assign rx = sync_q[1];

    assign last_bit = BW'(char_bits(len_code) - 4'd1);

    // completed character as seen at the stop-bit sample
    always_comb begin
        frame_brk = !rx && (shreg == '0) && ((mode == PM_NONE) || !pbit);
        frame_entry.data = shreg;
        frame_entry.ferr = !rx;
        frame_entry.brk  = frame_brk;
        frame_entry.perr = frame_brk ? 1'b0 : par_flag(shreg, pbit, mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RS_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            pbit      <= 1'b0;
            start_ok  <= 1'b0;
            char_done <= 1'b0;
            char_out  <= '0;
        end else begin
            start_ok  <= 1'b0;
            char_done <= 1'b0;
            if (tick) begin
                unique case (state)
                    RS_IDLE: begin
                        if (!rx) begin
                            state <= RS_START;
                            cnt   <= '0;
                        end
                    end
                    RS_START: begin
                        if (cnt == HALF) begin
                            cnt <= '0;
                            if (!rx) begin
                                state    <= RS_DATA;
                                start_ok <= 1'b1;
                                shreg    <= '0;
                                bit_idx  <= '0;
                                pbit     <= 1'b0;
                            end else begin
                                state <= RS_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RS_DATA: begin
                        if (cnt == LAST) begin
                            cnt            <= '0;
                            shreg[bit_idx] <= rx;
                            if (bit_idx == last_bit)
                                state <= (mode == PM_NONE) ? RS_STOP : RS_PAR;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RS_PAR: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            pbit  <= rx;
                            state <= RS_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RS_STOP: begin
                        if (cnt == LAST) begin
                            cnt       <= '0;
                            char_done <= 1'b1;
                            char_out  <= frame_entry;
                            state     <= frame_brk ? RS_BRKWAIT : RS_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RS_BRKWAIT: begin
                        if (!rx) begin
                            cnt <= '0;
                        end else if (cnt == HALF) begin
                            cnt   <= '0;
                            state <= RS_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RS_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/urx_store.sv
module urx_store
    import urx_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      char_done,
    input  rx_entry_t char_in,
    input  logic      start_ok,
    input  logic      rd,
    input  logic      clr,
    output rx_entry_t head,
    output logic      ready,
    output logic      full,
    output logic      ovr
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);

    rx_entry_t     mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] count;
    rx_entry_t     hold;
    logic          hold_v;

    logic          pop;
    logic          space;
    logic          src_v;
    rx_entry_t     src;
    logic          do_wr;
    logic          ovr_set;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PTR_MAX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        pop     = rd && (count != '0);
        space   = (count != CNT_MAX) || pop;
        src_v   = hold_v || char_done;
        src     = hold_v ? hold : char_in;
        do_wr   = src_v && space;
        ovr_set = hold_v && !do_wr && (char_done || start_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wr_ptr <= '0;
        end else if (do_wr) begin
            mem[wr_ptr] <= src;
            wr_ptr      <= bump(wr_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop) rd_ptr <= bump(rd_ptr);
            unique case ({do_wr, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // single holding stage behind a full queue
    always_ff @(posedge clk) begin
        if (rst) begin
            hold   <= '0;
            hold_v <= 1'b0;
        end else if (hold_v) begin
            if (do_wr) begin
                hold_v <= char_done;
                if (char_done) hold <= char_in;
            end else if (char_done) begin
                hold <= char_in;
            end else if (start_ok) begin
                hold_v <= 1'b0;
            end
        end else if (char_done && !space) begin
            hold   <= char_in;
            hold_v <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ovr <= 1'b0;
        else if (ovr_set) ovr <= 1'b1;
        else if (clr)     ovr <= 1'b0;
    end

    assign head  = mem[rd_ptr];
    assign ready = (count != '0);
    assign full  = (count == CNT_MAX);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import urx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              rxd,
    input  logic [1:0]        len_code,
    input  logic [1:0]        par_mode,
    input  logic              rd_strobe,
    input  logic              clr_err,
    output logic              rx_ready,
    output logic              fifo_full,
    output logic              overrun,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_break,
    output logic              rx_ferr,
    output logic              rx_perr
);

    logic      start_ok;
    logic      char_done;
    rx_entry_t char_ent;
    rx_entry_t head;
    par_mode_t mode;

    assign mode = par_mode_t'(par_mode);

    urx_sampler #(.OVS(OVS)) u_samp (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .rxd_async (rxd),
        .len_code  (len_code),
        .mode      (mode),
        .start_ok  (start_ok),
        .char_done (char_done),
        .char_out  (char_ent)
    );

    urx_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .char_done (char_done),
        .char_in   (char_ent),
        .start_ok  (start_ok),
        .rd        (rd_strobe),
        .clr       (clr_err),
        .head      (head),
        .ready     (rx_ready),
        .full      (fifo_full),
        .ovr       (overrun)
    );

    assign rx_data  = head.data;
    assign rx_break = head.brk;
    assign rx_ferr  = head.ferr;
    assign rx_perr  = head.perr;

endmodule

// File: rtl/urx_checker.sv
module urx_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_ready,
    input logic       fifo_full,
    input logic       overrun,
    input logic       rd_strobe,
    input logic       clr_err,
    input logic [7:0] rx_data,
    input logic       rx_break
);

    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> rx_ready); // R8

    AST_READY_DROP_ON_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_ready) |-> $past(rd_strobe)); // R7

    AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && !rd_strobe) |=> (rx_ready && $stable(rx_data))); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clr_err) |=> overrun); // R10

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(fifo_full)); // R9

    AST_BREAK_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && rx_break) |-> (rx_data == 8'h00)); // R5

endmodule

bind uart_rx_status urx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_ready  (rx_ready),
    .fifo_full (fifo_full),
    .overrun   (overrun),
    .rd_strobe (rd_strobe),
    .clr_err   (clr_err),
    .rx_data   (rx_data),
    .rx_break  (rx_break)
);

// File: tb/sim_uart_rx_status.sv
`timescale 1ns/1ps
module sim_uart_rx_status;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick;
    logic       rxd = 1'b1;
    logic [1:0] len_code = 2'd3;
    logic [1:0] par_mode = 2'd0;
    logic       rd_strobe = 1'b0;
    logic       clr_err = 1'b0;
    logic       rx_ready, fifo_full, overrun;
    logic [7:0] rx_data;
    logic       rx_break, rx_ferr, rx_perr;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    // reference model: {brk, ferr, perr, data}
    logic [10:0] mq[$];
    logic [10:0] m_hold;
    bit          m_hold_v = 0;
    bit          m_ovr = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) tick <= 1'b0;
        else     tick <= ~tick;
    end

    uart_rx_status u0 (
        .clk(clk), .rst(rst), .baud_tick(tick), .rxd(rxd),
        .len_code(len_code), .par_mode(par_mode),
        .rd_strobe(rd_strobe), .clr_err(clr_err),
        .rx_ready(rx_ready), .fifo_full(fifo_full), .overrun(overrun),
        .rx_data(rx_data), .rx_break(rx_break), .rx_ferr(rx_ferr), .rx_perr(rx_perr)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        chk(tag, "rx_ready", int'(rx_ready), int'(mq.size() > 0));
        chk(tag, "fifo_full", int'(fifo_full), int'(mq.size() == 3));
        chk(tag, "overrun", int'(overrun), int'(m_ovr));
        if (mq.size() > 0) begin
            chk(tag, "rx_data", int'(rx_data), int'(mq[0][7:0]));
            chk(tag, "rx_break", int'(rx_break), int'(mq[0][10]));
            chk(tag, "rx_ferr", int'(rx_ferr), int'(mq[0][9]));
            chk(tag, "rx_perr", int'(rx_perr), int'(mq[0][8]));
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic model_push(input logic [10:0] e);
        if (mq.size() < 3) mq.push_back(e);
        else if (!m_hold_v) begin
            m_hold = e;
            m_hold_v = 1;
        end
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        if (mq.size() > 0) void'(mq.pop_front());
        if (m_hold_v && mq.size() < 3) begin
            mq.push_back(m_hold);
            m_hold_v = 0;
        end
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit flip, input bit md_bit,
                              input int stop_low);
        int nb;
        logic [7:0] md;
        logic pb;
        nb = 5 + int'(len_code);
        md = d & 8'((1 << nb) - 1);
        if (m_hold_v && mq.size() == 3) begin
            m_hold_v = 0;
            m_ovr = 1;
        end
        rxd = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < nb; i++) begin
            rxd = md[i];
            wait_ticks(16);
        end
        if (par_mode != 2'd0) begin
            if (par_mode == 2'd3)      pb = md_bit;
            else if (par_mode == 2'd1) pb = (^md) ^ flip;
            else                       pb = ~(^md) ^ flip;
            rxd = pb;
            wait_ticks(16);
        end
        if (stop_low > 0) begin
            rxd = 1'b0;
            wait_ticks(stop_low);
        end
        rxd = 1'b1;
        wait_ticks(32);
        model_push({1'b0, (stop_low > 0) ? 1'b1 : 1'b0,
                    (par_mode == 2'd3) ? md_bit : ((par_mode == 2'd0) ? 1'b0 : flip), md});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R11: quiet after reset
        check_state("R11");

        // R1: eight data bits, no parity
        len_code = 2'd3; par_mode = 2'd0;
        send_frame(8'hA5, 0, 0, 0);
        check_state("R1");
        do_read();
        check_state("R7");

        // R1: five data bits, upper bits must read zero
        len_code = 2'd0;
        send_frame(8'hF3, 0, 0, 0);
        check_state("R1");
        do_read();

        // R2: even good, even corrupted, odd good; three entries fill the queue (R8)
        len_code = 2'd3; par_mode = 2'd1;
        send_frame(8'h3C, 0, 0, 0);
        send_frame(8'h3C, 1, 0, 0);
        par_mode = 2'd2;
        send_frame(8'h81, 0, 0, 0);
        check_state("R8");
        do_read();
        check_state("R2");
        do_read();
        check_state("R2");
        do_read();
        check_state("R7");

        // R3: multidrop marker stored in the parity flag
        par_mode = 2'd3;
        send_frame(8'h11, 0, 1, 0);
        send_frame(8'h22, 0, 0, 0);
        check_state("R3");
        do_read();
        check_state("R3");
        do_read();

        // R4: low stop bit without break
        par_mode = 2'd0;
        send_frame(8'h55, 0, 0, 11);
        check_state("R4");
        do_read();
        check_state("R4");

        // R5 / R6: long break, short glitch, more low, then release
        rxd = 1'b0;
        wait_ticks(400);
        rxd = 1'b1;
        wait_ticks(3);
        rxd = 1'b0;
        wait_ticks(100);
        rxd = 1'b1;
        wait_ticks(32);
        model_push({1'b1, 1'b1, 1'b0, 8'h00});
        check_state("R5");
        send_frame(8'h7E, 0, 0, 0);
        check_state("R6");
        do_read();
        check_state("R6");
        do_read();
        check_state("R6");

        // R8 / R9 / R10: fill, hold, overrun, clear
        send_frame(8'h01, 0, 0, 0);
        send_frame(8'h02, 0, 0, 0);
        send_frame(8'h03, 0, 0, 0);
        send_frame(8'h04, 0, 0, 0);
        check_state("R8");
        send_frame(8'h05, 0, 0, 0);
        check_state("R9");
        do_read();
        check_state("R10");
        @(negedge clk) clr_err = 1'b1;
        @(negedge clk) clr_err = 1'b0;
        m_ovr = 0;
        @(negedge clk);
        check_state("R10");
        do_read();
        check_state("R9");
        do_read();
        check_state("R9");
        do_read();
        check_state("R7");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule